// File: doc/BRIEF.md
# Exception Entry Sequencer

This block runs the entry half of exception handling for a small 32-bit processor core. After the asynchronous reset is released it starts a power-on entry by itself. It reads the first program counter and the first stack pointer from two fixed words at the bottom of memory. It then reports a reset-style completion, so that the core clears its vector base and register-bank state. Later requests are tagged with a kind, a vector number and a priority level. A manual reset request follows the same path through a second pair of fixed words.

Every other kind saves context on a stack that grows downward from the current stack pointer. The status word goes to SP-4 and the program counter to SP-8. The block then reads the handler address from the vector base plus four times the vector number. An interrupt also copies its priority level into the status word's mask field.

All traffic goes through one 32-bit word port with a request/ready handshake. The new PC, SP and status word are reported with a one-cycle done pulse. While a sequence runs, the block raises busy and ignores new requests.

Top module: `exc_entry_seq`

## Requirements
- R1: While `rst_ni` is low, `mem_req_o` and `done_o` are 0 and `busy_o` is 1. After release, a power-on entry reads the word at 0x00000000, then the word at 0x00000004. It ends with `pc_o` set to the first word and `sp_o` set to the second.
- R2: `req_kind_i` = 3 (manual reset) reads 0x00000008 and then 0x0000000C. `pc_o` gets the first word and `sp_o` the second.
- R3: Both reset entries end with `sr_o` = 0x000000F0: mask field bits [7:4] at 0xF, and every other bit 0, including the bank-overflow bit 14 and the bank-count bit 13. `init_o` is high with `done_o`, so the core clears its vector base and bank number. `init_o` is low for every other kind.
- R4: Kinds 0 (interrupt), 1 (address error) and 2 (instruction) first write `cur_sr_i` to `cur_sp_i`-4, then write `cur_pc_i` to `cur_sp_i`-8. These are 32-bit wraparound subtractions. The entry ends with `sp_o` = `cur_sp_i`-8.
- R5: After the two saves, one read is made at `cur_vbr_i` + 4·`req_vec_i` (modulo 2^32). `pc_o` gets the word read.
- R6: For kind 0, `sr_o` equals `cur_sr_i` with bits [7:4] replaced by `req_level_i`.
- R7: For kinds 1 and 2, `sr_o` equals `cur_sr_i` unchanged.
- R8: Each access keeps `mem_req_o`, `mem_addr_o`, `mem_we_o` and `mem_wdata_o` steady until `mem_ready_i` is sampled high. The result does not depend on how many wait cycles the memory adds.
- R9: `done_o` is high for exactly one cycle, the cycle after the final access's ready. Requests raised while `busy_o` is high are ignored and start no memory traffic.
- R10: Reset entries make no write access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset; release starts the power-on entry |
| req_valid_i | input | 1 | Exception request, taken when the block is idle |
| req_kind_i | input | 2 | 0 interrupt, 1 address error, 2 instruction, 3 manual reset |
| req_vec_i | input | 8 | Vector number |
| req_level_i | input | 4 | Interrupt priority level |
| cur_pc_i | input | 32 | PC to save |
| cur_sp_i | input | 32 | Current stack pointer (R15) |
| cur_sr_i | input | 32 | Current status word |
| cur_vbr_i | input | 32 | Current vector base |
| busy_o | output | 1 | Sequence in progress |
| mem_req_o | output | 1 | Memory access request |
| mem_we_o | output | 1 | 1 for write |
| mem_addr_o | output | 32 | Byte address of the word |
| mem_wdata_o | output | 32 | Write data |
| mem_rdata_i | input | 32 | Read data, valid with ready |
| mem_ready_i | input | 1 | Access completes in this cycle |
| done_o | output | 1 | One-cycle completion pulse |
| init_o | output | 1 | Completion was a reset entry |
| pc_o | output | 32 | New program counter |
| sp_o | output | 32 | New stack pointer |
| sr_o | output | 32 | New status word |

## Verification
Some properties are checked on every cycle:
- a stalled access keeps its address, data and direction steady;
- reset entries never write;
- done is a single-cycle pulse;
- a request raised while busy leaves the captured kind untouched;
- at each completion, the reported SP and status word match the saved SP, the saved status and the level as each kind requires.

The address and data sequence of each entry shows only in the bench's scenarios. So do the handler address with its wraparound, the values taken from memory, and the absence of traffic after an ignored request. The bench drives varied wait states and stack pointers near zero.

// File: rtl/exc_seq_pkg.sv
package exc_seq_pkg;

  typedef enum logic [2:0] {
    KIND_IRQ   = 3'd0,
    KIND_ADDR  = 3'd1,
    KIND_INSTR = 3'd2,
    KIND_MRST  = 3'd3,
    KIND_POR   = 3'd4
  } exc_kind_e;

  typedef enum logic [2:0] {
    ST_BOOT = 3'd0,
    ST_IDLE = 3'd1,
    ST_RPC  = 3'd2,
    ST_RSP  = 3'd3,
    ST_WSR  = 3'd4,
    ST_WPC  = 3'd5,
    ST_RVEC = 3'd6
  } seq_st_e;

  function automatic logic kind_is_reset(exc_kind_e k);
    return (k == KIND_MRST) || (k == KIND_POR);
  endfunction

endpackage

// File: rtl/exc_seq_fsm.sv
module exc_seq_fsm
  import exc_seq_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       req_valid_i,
  input  logic [1:0] req_kind_i,
  input  logic       mem_ready_i,
  output seq_st_e    state_o,
  output exc_kind_e  kind_o,
  output logic       accept_o,
  output logic       fin_o,
  output logic       busy_o,
  output logic       mem_req_o
);

  seq_st_e   st_q, st_d;
  exc_kind_e kind_q, kind_d;
  logic      hs;

  assign mem_req_o = (st_q != ST_BOOT) && (st_q != ST_IDLE);
  assign hs        = mem_req_o && mem_ready_i;
  assign busy_o    = (st_q != ST_IDLE);
  assign accept_o  = (st_q == ST_IDLE) && req_valid_i;

  always_comb begin
    st_d   = st_q;
    kind_d = kind_q;
    fin_o  = 1'b0;
    unique case (st_q)
      ST_BOOT: begin
        st_d   = ST_RPC;
        kind_d = KIND_POR;
      end
      ST_IDLE: if (req_valid_i) begin
        kind_d = exc_kind_e'({1'b0, req_kind_i});
        st_d   = (kind_d == KIND_MRST) ? ST_RPC : ST_WSR;
      end
      ST_RPC:  if (hs) st_d = ST_RSP;
      ST_RSP:  if (hs) begin st_d = ST_IDLE; fin_o = 1'b1; end
      ST_WSR:  if (hs) st_d = ST_WPC;
      ST_WPC:  if (hs) st_d = ST_RVEC;
      ST_RVEC: if (hs) begin st_d = ST_IDLE; fin_o = 1'b1; end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_BOOT;
      kind_q <= KIND_POR;
    end else begin
      st_q   <= st_d;
      kind_q <= kind_d;
    end
  end

  assign state_o = st_q;
  assign kind_o  = kind_q;

  AST_STALL_HOLDS_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && !mem_ready_i |=> mem_req_o && $stable(st_q)); // R8
  AST_BUSY_IGNORES_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && req_valid_i |=> $stable(kind_q)); // R9
  AST_FIN_ONLY_ON_READY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fin_o |-> mem_ready_i && !busy_o == 1'b0); // R9

endmodule

// File: rtl/exc_req_latch.sv
module exc_req_latch #(
  parameter int XLEN  = 32,
  parameter int VEC_W = 8,
  parameter int LVL_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             accept_i,
  input  logic [VEC_W-1:0] vec_i,
  input  logic [LVL_W-1:0] level_i,
  input  logic [XLEN-1:0]  pc_i,
  input  logic [XLEN-1:0]  sp_i,
  input  logic [XLEN-1:0]  sr_i,
  input  logic [XLEN-1:0]  vbr_i,
  output logic [VEC_W-1:0] vec_o,
  output logic [LVL_W-1:0] level_o,
  output logic [XLEN-1:0]  pc_o,
  output logic [XLEN-1:0]  sp_o,
  output logic [XLEN-1:0]  sr_o,
  output logic [XLEN-1:0]  vbr_o
);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vec_o   <= '0;
      level_o <= '0;
      pc_o    <= '0;
      sp_o    <= '0;
      sr_o    <= '0;
      vbr_o   <= '0;
    end else if (accept_i) begin
      vec_o   <= vec_i;
      level_o <= level_i;
      pc_o    <= pc_i;
      sp_o    <= sp_i;
      sr_o    <= sr_i;
      vbr_o   <= vbr_i;
    end
  end

endmodule

// File: rtl/exc_addr_gen.sv
module exc_addr_gen
  import exc_seq_pkg::*;
#(
  parameter int          XLEN       = 32,
  parameter int          VEC_W      = 8,
  parameter int          WORD_BYTES = 4,
  parameter logic [31:0] POR_BASE   = 32'h0000_0000,
  parameter logic [31:0] MRST_BASE  = 32'h0000_0008
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  seq_st_e          state_i,
  input  exc_kind_e        kind_i,
  input  logic             mem_req_i,
  input  logic             mem_ready_i,
  input  logic [VEC_W-1:0] vec_i,
  input  logic [XLEN-1:0]  pc_i,
  input  logic [XLEN-1:0]  sp_i,
  input  logic [XLEN-1:0]  sr_i,
  input  logic [XLEN-1:0]  vbr_i,
  output logic             mem_we_o,
  output logic [XLEN-1:0]  mem_addr_o,
  output logic [XLEN-1:0]  mem_wdata_o
);

  localparam int          SHIFT = $clog2(WORD_BYTES);
  localparam logic [XLEN-1:0] WORD = XLEN'(WORD_BYTES);

  logic [XLEN-1:0] rst_base;
  logic [XLEN-1:0] vec_off;

  assign rst_base = (kind_i == KIND_MRST) ? XLEN'(MRST_BASE) : XLEN'(POR_BASE);
  assign vec_off  = XLEN'(vec_i) << SHIFT;

  always_comb begin
    mem_we_o    = 1'b0;
    mem_addr_o  = '0;
    mem_wdata_o = '0;
    unique case (state_i)
      ST_RPC:  mem_addr_o = rst_base;
      ST_RSP:  mem_addr_o = rst_base + WORD;
      ST_WSR: begin
        mem_we_o    = 1'b1;
        mem_addr_o  = sp_i - WORD;
        mem_wdata_o = sr_i;
      end
      ST_WPC: begin
        mem_we_o    = 1'b1;
        mem_addr_o  = sp_i - (WORD << 1);
        mem_wdata_o = pc_i;
      end
      ST_RVEC: mem_addr_o = vbr_i + vec_off;
      default: ;
    endcase
  end

  AST_ADDR_HELD_IN_STALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_i && !mem_ready_i |=> $stable(mem_addr_o) && $stable(mem_we_o) && $stable(mem_wdata_o)); // R8
  AST_NO_WRITE_IN_RESET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_i && mem_we_o |-> !kind_is_reset(kind_i)); // R10

endmodule

// File: rtl/exc_ctx_regs.sv
module exc_ctx_regs
  import exc_seq_pkg::*;
#(
  parameter int XLEN     = 32,
  parameter int LVL_W    = 4,
  parameter int MASK_LSB = 4,
  parameter int WORD_BYTES = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  seq_st_e          state_i,
  input  exc_kind_e        kind_i,
  input  logic             hs_i,
  input  logic             fin_i,
  input  logic [XLEN-1:0]  rdata_i,
  input  logic [XLEN-1:0]  sp_i,
  input  logic [XLEN-1:0]  sr_i,
  input  logic [LVL_W-1:0] level_i,
  output logic             done_o,
  output logic             init_o,
  output logic [XLEN-1:0]  pc_o,
  output logic [XLEN-1:0]  sp_o,
  output logic [XLEN-1:0]  sr_o
);

  localparam logic [XLEN-1:0] SR_RESET = XLEN'(((1 << LVL_W) - 1) << MASK_LSB);
  localparam logic [XLEN-1:0] FRAME    = XLEN'(2 * WORD_BYTES);

  logic [XLEN-1:0] sr_irq;

  always_comb begin
    sr_irq = sr_i;
    sr_irq[MASK_LSB +: LVL_W] = level_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pc_o   <= '0;
      sp_o   <= '0;
      sr_o   <= '0;
      done_o <= 1'b0;
      init_o <= 1'b0;
    end else begin
      done_o <= fin_i;
      init_o <= fin_i && kind_is_reset(kind_i);
      if (hs_i) begin
        unique case (state_i)
          ST_RPC: pc_o <= rdata_i;
          ST_RSP: begin
            sp_o <= rdata_i;
            sr_o <= SR_RESET;
          end
          ST_WPC: begin
            sp_o <= sp_i - FRAME;
            sr_o <= (kind_i == KIND_IRQ) ? sr_irq : sr_i;
          end
          ST_RVEC: pc_o <= rdata_i;
          default: ;
        endcase
      end
    end
  end

  AST_DONE_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R9
  AST_INIT_SR_VALUE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    init_o |-> done_o && sr_o == SR_RESET); // R3
  AST_FRAME_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && !kind_is_reset(kind_i) |-> sp_o == sp_i - FRAME && !init_o); // R4
  AST_IRQ_LEVEL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && kind_i == KIND_IRQ |-> sr_o[MASK_LSB +: LVL_W] == level_i); // R6
  AST_FAULT_KEEPS_SR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && (kind_i == KIND_ADDR || kind_i == KIND_INSTR) |-> sr_o == sr_i); // R7

endmodule

// File: rtl/exc_entry_seq.sv
module exc_entry_seq
  import exc_seq_pkg::*;
#(
  parameter int          XLEN       = 32,
  parameter int          VEC_W      = 8,
  parameter int          LVL_W      = 4,
  parameter int          MASK_LSB   = 4,
  parameter int          WORD_BYTES = 4,
  parameter logic [31:0] POR_BASE   = 32'h0000_0000,
  parameter logic [31:0] MRST_BASE  = 32'h0000_0008
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_valid_i,
  input  logic [1:0]       req_kind_i,
  input  logic [VEC_W-1:0] req_vec_i,
  input  logic [LVL_W-1:0] req_level_i,
  input  logic [XLEN-1:0]  cur_pc_i,
  input  logic [XLEN-1:0]  cur_sp_i,
  input  logic [XLEN-1:0]  cur_sr_i,
  input  logic [XLEN-1:0]  cur_vbr_i,
  output logic             busy_o,
  output logic             mem_req_o,
  output logic             mem_we_o,
  output logic [XLEN-1:0]  mem_addr_o,
  output logic [XLEN-1:0]  mem_wdata_o,
  input  logic [XLEN-1:0]  mem_rdata_i,
  input  logic             mem_ready_i,
  output logic             done_o,
  output logic             init_o,
  output logic [XLEN-1:0]  pc_o,
  output logic [XLEN-1:0]  sp_o,
  output logic [XLEN-1:0]  sr_o
);

  seq_st_e          state;
  exc_kind_e        kind;
  logic             accept, fin, hs;
  logic [VEC_W-1:0] vec_q;
  logic [LVL_W-1:0] level_q;
  logic [XLEN-1:0]  pc_q, sp_q, sr_q, vbr_q;

  assign hs = mem_req_o && mem_ready_i;

  exc_seq_fsm u_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .req_valid_i (req_valid_i),
    .req_kind_i  (req_kind_i),
    .mem_ready_i (mem_ready_i),
    .state_o     (state),
    .kind_o      (kind),
    .accept_o    (accept),
    .fin_o       (fin),
    .busy_o      (busy_o),
    .mem_req_o   (mem_req_o)
  );

  exc_req_latch #(.XLEN(XLEN), .VEC_W(VEC_W), .LVL_W(LVL_W)) u_latch (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .accept_i (accept),
    .vec_i    (req_vec_i),
    .level_i  (req_level_i),
    .pc_i     (cur_pc_i),
    .sp_i     (cur_sp_i),
    .sr_i     (cur_sr_i),
    .vbr_i    (cur_vbr_i),
    .vec_o    (vec_q),
    .level_o  (level_q),
    .pc_o     (pc_q),
    .sp_o     (sp_q),
    .sr_o     (sr_q),
    .vbr_o    (vbr_q)
  );

  exc_addr_gen #(
    .XLEN(XLEN), .VEC_W(VEC_W), .WORD_BYTES(WORD_BYTES),
    .POR_BASE(POR_BASE), .MRST_BASE(MRST_BASE)
  ) u_addr (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .state_i     (state),
    .kind_i      (kind),
    .mem_req_i   (mem_req_o),
    .mem_ready_i (mem_ready_i),
    .vec_i       (vec_q),
    .pc_i        (pc_q),
    .sp_i        (sp_q),
    .sr_i        (sr_q),
    .vbr_i       (vbr_q),
    .mem_we_o    (mem_we_o),
    .mem_addr_o  (mem_addr_o),
    .mem_wdata_o (mem_wdata_o)
  );

  exc_ctx_regs #(
    .XLEN(XLEN), .LVL_W(LVL_W), .MASK_LSB(MASK_LSB), .WORD_BYTES(WORD_BYTES)
  ) u_ctx (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .state_i (state),
    .kind_i  (kind),
    .hs_i    (hs),
    .fin_i   (fin),
    .rdata_i (mem_rdata_i),
    .sp_i    (sp_q),
    .sr_i    (sr_q),
    .level_i (level_q),
    .done_o  (done_o),
    .init_o  (init_o),
    .pc_o    (pc_o),
    .sp_o    (sp_o),
    .sr_o    (sr_o)
  );

  AST_RESET_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> !done_o); // R9

endmodule

// File: tb/exc_entry_seq_bench.sv
module exc_entry_seq_bench;

  typedef struct packed {
    logic [1:0]  kind;
    logic [7:0]  vec;
    logic [3:0]  lvl;
    logic [1:0]  lat;
    logic [31:0] pc;
    logic [31:0] sp;
    logic [31:0] sr;
    logic [31:0] vbr;
  } vec_t;

  localparam int NV = 6;
  localparam vec_t VECS [NV] = '{
    '{2'd0, 8'h40, 4'h9, 2'd0, 32'h0000_1234, 32'h0001_0000, 32'h0000_6003, 32'h0000_0000},
    '{2'd1, 8'h09, 4'h3, 2'd2, 32'h0000_2A2A, 32'h0000_8F00, 32'h0000_00F1, 32'h0400_0000},
    '{2'd2, 8'h04, 4'h5, 2'd1, 32'h8000_0010, 32'h0000_0100, 32'h0000_0051, 32'h0000_0100},
    '{2'd3, 8'h22, 4'h1, 2'd1, 32'h0000_5555, 32'h0000_7777, 32'hFFFF_FFFF, 32'h0000_1000},
    '{2'd0, 8'hFF, 4'hF, 2'd3, 32'h0000_0ABC, 32'h0000_0000, 32'h0000_4000, 32'hFFFF_FC00},
    '{2'd0, 8'h00, 4'h0, 2'd0, 32'h0000_0004, 32'h0000_2000, 32'hFFFF_FFFF, 32'h0000_0800}
  };

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_valid = 1'b0;
  logic [1:0]  req_kind = '0;
  logic [7:0]  req_vec = '0;
  logic [3:0]  req_level = '0;
  logic [31:0] cur_pc = '0, cur_sp = '0, cur_sr = '0, cur_vbr = '0;
  logic        busy_o, mem_req_o, mem_we_o, done_o, init_o;
  logic [31:0] mem_addr_o, mem_wdata_o, pc_o, sp_o, sr_o;
  logic [31:0] mem_rdata = '0;
  logic        mem_ready = 1'b0;

  int checks = 0;
  int errors = 0;
  int lat = 0;
  int wc = 0;
  int n_acc = 0;
  logic [31:0] log_a [64];
  logic [31:0] log_d [64];
  logic        log_we [64];

  always #4 clk = ~clk;

  exc_entry_seq u_exc_entry_seq (
    .clk_i(clk), .rst_ni(rst_ni),
    .req_valid_i(req_valid), .req_kind_i(req_kind), .req_vec_i(req_vec), .req_level_i(req_level),
    .cur_pc_i(cur_pc), .cur_sp_i(cur_sp), .cur_sr_i(cur_sr), .cur_vbr_i(cur_vbr),
    .busy_o(busy_o), .mem_req_o(mem_req_o), .mem_we_o(mem_we_o),
    .mem_addr_o(mem_addr_o), .mem_wdata_o(mem_wdata_o),
    .mem_rdata_i(mem_rdata), .mem_ready_i(mem_ready),
    .done_o(done_o), .init_o(init_o), .pc_o(pc_o), .sp_o(sp_o), .sr_o(sr_o)
  );

  function automatic logic [31:0] mem_word(logic [31:0] a);
    return {a[15:0], ~a[15:0]} ^ 32'h6B2D_9E44;
  endfunction

  // memory model: ready after lat+1 cycles of request
  always @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      mem_ready <= 1'b0;
      wc <= 0;
    end else if (mem_ready) begin
      mem_ready <= 1'b0;
      wc <= 0;
      log_a[n_acc % 64]  <= mem_addr_o;
      log_d[n_acc % 64]  <= mem_wdata_o;
      log_we[n_acc % 64] <= mem_we_o;
      n_acc <= n_acc + 1;
    end else if (mem_req_o) begin
      if (wc == lat) begin
        mem_ready <= 1'b1;
        mem_rdata <= mem_word(mem_addr_o);
      end else begin
        wc <= wc + 1;
      end
    end
  end

  task automatic chk(input logic ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic wait_done(input string req);
    int n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!done_o && n < 300);
    chk(done_o, req, "done seen", 32'(done_o), 32'd1);
  endtask

  task automatic issue(input logic [1:0] k, input logic [7:0] v, input logic [3:0] l,
                       input logic [31:0] pc, input logic [31:0] sp,
                       input logic [31:0] sr, input logic [31:0] vbr);
    @(negedge clk);
    req_kind = k; req_vec = v; req_level = l;
    cur_pc = pc; cur_sp = sp; cur_sr = sr; cur_vbr = vbr;
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic chk_acc(input int idx, input logic we, input logic [31:0] a,
                         input logic [31:0] d, input string req);
    chk(log_we[idx % 64] == we, req, "access dir", 32'(log_we[idx % 64]), 32'(we));
    chk(log_a[idx % 64] == a, req, "access addr", log_a[idx % 64], a);
    if (we) chk(log_d[idx % 64] == d, req, "write data", log_d[idx % 64], d);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : main
    int base;
    logic [31:0] exp_sr, va;
    // R1 reset state
    repeat (3) @(negedge clk);
    chk(!mem_req_o, "R1", "mem_req in reset", 32'(mem_req_o), 32'd0);
    chk(!done_o, "R1", "done in reset", 32'(done_o), 32'd0);
    chk(busy_o, "R1", "busy in reset", 32'(busy_o), 32'd1);
    base = n_acc;
    rst_ni = 1'b1;
    wait_done("R1");
    chk(pc_o == mem_word(32'h0), "R1", "por pc", pc_o, mem_word(32'h0));
    chk(sp_o == mem_word(32'h4), "R1", "por sp", sp_o, mem_word(32'h4));
    chk(sr_o == 32'h0000_00F0, "R3", "por sr", sr_o, 32'h0000_00F0);
    chk(init_o, "R3", "por init", 32'(init_o), 32'd1);
    @(negedge clk);
    chk(n_acc - base == 2, "R10", "por access count", 32'(n_acc - base), 32'd2);
    chk_acc(base, 1'b0, 32'h0, 32'h0, "R1");
    chk_acc(base + 1, 1'b0, 32'h4, 32'h0, "R1");
    chk(!done_o, "R9", "done width", 32'(done_o), 32'd0);

    // table walk; lat varies for R8
    for (int i = 0; i < NV; i++) begin
      lat = int'(VECS[i].lat);
      base = n_acc;
      issue(VECS[i].kind, VECS[i].vec, VECS[i].lvl, VECS[i].pc, VECS[i].sp, VECS[i].sr, VECS[i].vbr);
      wait_done("R9");
      if (VECS[i].kind == 2'd3) begin
        chk(pc_o == mem_word(32'h8), "R2", "mrst pc", pc_o, mem_word(32'h8));
        chk(sp_o == mem_word(32'hC), "R2", "mrst sp", sp_o, mem_word(32'hC));
        chk(sr_o == 32'h0000_00F0, "R3", "mrst sr", sr_o, 32'h0000_00F0);
        chk(init_o, "R3", "mrst init", 32'(init_o), 32'd1);
        @(negedge clk);
        chk(n_acc - base == 2, "R10", "mrst access count", 32'(n_acc - base), 32'd2);
        chk_acc(base, 1'b0, 32'h8, 32'h0, "R2");
        chk_acc(base + 1, 1'b0, 32'hC, 32'h0, "R2");
      end else begin
        va = VECS[i].vbr + {22'd0, VECS[i].vec, 2'b00};
        exp_sr = VECS[i].sr;
        if (VECS[i].kind == 2'd0) exp_sr[7:4] = VECS[i].lvl;
        chk(pc_o == mem_word(va), "R5", "handler pc", pc_o, mem_word(va));
        chk(sp_o == VECS[i].sp - 32'd8, "R4", "new sp", sp_o, VECS[i].sp - 32'd8);
        chk(sr_o == exp_sr, (VECS[i].kind == 2'd0) ? "R6" : "R7", "new sr", sr_o, exp_sr);
        chk(!init_o, "R3", "init low", 32'(init_o), 32'd0);
        @(negedge clk);
        chk(n_acc - base == 3, "R4", "access count", 32'(n_acc - base), 32'd3);
        chk_acc(base, 1'b1, VECS[i].sp - 32'd4, VECS[i].sr, "R4");
        chk_acc(base + 1, 1'b1, VECS[i].sp - 32'd8, VECS[i].pc, "R4");
        chk_acc(base + 2, 1'b0, va, 32'h0, "R5");
      end
      chk(!done_o, "R9", "done width", 32'(done_o), 32'd0);
    end

    // R9 requests during busy are ignored
    lat = 1;
    base = n_acc;
    issue(2'd0, 8'h10, 4'h2, 32'h0000_0100, 32'h0000_4000, 32'h0, 32'h0000_2000);
    req_kind = 2'd3; req_vec = 8'h77; req_valid = 1'b1;
    repeat (3) @(negedge clk);
    req_valid = 1'b0;
    wait_done("R9");
    chk(pc_o == mem_word(32'h2040), "R9", "busy req ignored pc", pc_o, mem_word(32'h2040));
    chk(!init_o, "R9", "busy req no reset", 32'(init_o), 32'd0);
    repeat (8) @(negedge clk);
    chk(n_acc - base == 3, "R9", "no extra traffic", 32'(n_acc - base), 32'd3);
    chk(!busy_o, "R9", "idle after", 32'(busy_o), 32'd0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule